// File: doc/BRIEF.md
# HDLC Receive and Transmit Error Statistics

This block keeps five 16-bit event tallies for one HDLC channel. At the end of each received frame, the receiver raises a one-cycle strobe together with the frame's status. That status gives the CRC verdict, whether an overrun occurred, whether the address matched, whether a receive buffer was free, and whether the busy condition was active. Separately, the receiver pulses a strobe for each abort sequence, and the transmitter pulses a strobe for each frame it must resend after a collision. For every strobe, the block decides which tallies advance.

Software reaches the tallies through a simple select/write/read port. Reads are always available and combinational. A write takes effect only while the channel is disabled, so a driver can preset or clear the tallies before enabling the channel. While the channel runs, software cannot disturb them.

Top module: `hdlc_err_stats`

## Requirements
- R1: Every tally is 16 bits wide; incrementing 0xFFFF yields 0x0000.
- R2: A write (`reg_wr` high) while `chan_en` is high changes no tally.
- R3: A write while `chan_en` is low loads `reg_wdata` into the tally chosen by `reg_sel`: 0 = discarded frames, 1 = CRC errors, 2 = aborts, 3 = non-matching addresses, 4 = retransmissions. `reg_rdata` shows the selected tally in the same cycle.
- R4: With the channel enabled, an end-of-frame strobe with `rx_crc_bad` high and `rx_overrun` low advances the CRC-error tally by one. This holds whatever the address match and busy status are.
- R5: A frame that ends with `rx_overrun` high advances none of the frame-status tallies (CRC, discarded, non-matching).
- R6: Each cycle with `rx_abort` high while enabled advances the abort tally by one.
- R7: An error-free frame (no CRC error, no overrun) whose address did not match advances the non-matching-address tally by one.
- R8: Each cycle with `tx_retry` high while enabled advances the retransmission tally by one.
- R9: An error-free frame that matched its address but found no free buffer (`rx_no_buf`) or arrived while busy (`rx_busy`) advances the discarded-frame tally by one.
- R10: Events that arrive in the same cycle each advance their own tally by exactly one.
- R11: While `chan_en` is low, no strobe advances any tally. Changing `chan_en` alters no tally value.
- R12: After `rst_n` is asserted, every tally reads zero.
- R13: Select codes 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enabled; high blocks writes and allows counting |
| rx_eof | input | 1 | One-cycle end-of-frame strobe qualifying the status inputs |
| rx_crc_bad | input | 1 | Frame failed its CRC check |
| rx_overrun | input | 1 | Frame suffered a receive overrun |
| rx_addr_hit | input | 1 | Frame address matched this station |
| rx_no_buf | input | 1 | No free receive buffer for the frame |
| rx_busy | input | 1 | Busy condition active during the frame |
| rx_abort | input | 1 | One-cycle strobe per abort sequence |
| tx_retry | input | 1 | One-cycle strobe per collision retransmission |
| reg_sel | input | 3 | Tally select for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Selected tally value |

## Verification
A wrong qualification term appears as one tally that is off by one at the read port in the cycle after the offending strobe. It might advance for an overrun frame, or miss a busy-matched frame. Because the bench reads all five tallies after every status combination, the error shows within two cycles of the strobe that caused it. A wrong write gate either leaves a preset missing or lets a running-channel write show up immediately on `reg_rdata`. A broken wrap shows up as a nonzero read after a single event on a tally preset to 0xFFFF.

// File: rtl/hdlc_stat_pkg.sv
package hdlc_stat_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned N_CNT = 5;
  localparam int unsigned SEL_W = $clog2(N_CNT);

  typedef enum logic [SEL_W-1:0] {
    IDX_DISC = 3'd0,
    IDX_CRC  = 3'd1,
    IDX_ABT  = 3'd2,
    IDX_NMA  = 3'd3,
    IDX_RTX  = 3'd4
  } cnt_idx_e;

  typedef struct packed {
    logic eof;
    logic crc_bad;
    logic overrun;
    logic addr_hit;
    logic no_buf;
    logic busy;
    logic abort;
    logic retry;
  } stat_ev_t;
endpackage

// File: rtl/hdlc_stat_qualify.sv
module hdlc_stat_qualify
  import hdlc_stat_pkg::*;
(
  input  logic             run,
  input  stat_ev_t         ev,
  output logic [N_CNT-1:0] bump
);
  logic clean;
  logic frame;

  always_comb begin
    frame = run & ev.eof;
    clean = ~ev.crc_bad & ~ev.overrun;
    bump  = '0;
    bump[IDX_DISC] = frame & clean & ev.addr_hit & (ev.no_buf | ev.busy);
    bump[IDX_CRC]  = frame & ev.crc_bad & ~ev.overrun;
    bump[IDX_ABT]  = run & ev.abort;
    bump[IDX_NMA]  = frame & clean & ~ev.addr_hit;
    bump[IDX_RTX]  = run & ev.retry;
  end
endmodule

// File: rtl/hdlc_stat_counter.sv
module hdlc_stat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = load | bump;
    q_nxt = load ? load_val : q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/hdlc_stat_readmux.sv
module hdlc_stat_readmux #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 5,
  parameter int unsigned SW = 3
) (
  input  logic [SW-1:0]       sel,
  input  logic [N-1:0][W-1:0] cnt,
  output logic [W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == SW'(i)) rdata = cnt[i];
    end
  end
endmodule

// File: rtl/hdlc_err_stats.sv
module hdlc_err_stats
  import hdlc_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             rx_eof,
  input  logic             rx_crc_bad,
  input  logic             rx_overrun,
  input  logic             rx_addr_hit,
  input  logic             rx_no_buf,
  input  logic             rx_busy,
  input  logic             rx_abort,
  input  logic             tx_retry,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata
);
  logic [1:0]                 rst_pipe;
  logic                       rst_sn;
  stat_ev_t                   ev;
  logic [N_CNT-1:0]           bump;
  logic [N_CNT-1:0]           load;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_q;
  logic                       wr_ok;

  // reset asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  always_comb begin
    ev.eof      = rx_eof;
    ev.crc_bad  = rx_crc_bad;
    ev.overrun  = rx_overrun;
    ev.addr_hit = rx_addr_hit;
    ev.no_buf   = rx_no_buf;
    ev.busy     = rx_busy;
    ev.abort    = rx_abort;
    ev.retry    = tx_retry;
    wr_ok       = reg_wr & ~chan_en;
  end

  hdlc_stat_qualify u_qual (
    .run  (chan_en),
    .ev   (ev),
    .bump (bump)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    assign load[g] = wr_ok & (reg_sel == SEL_W'(g));
    hdlc_stat_counter #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_sn),
      .bump     (bump[g]),
      .load     (load[g]),
      .load_val (reg_wdata),
      .q        (cnt_q[g])
    );
  end

  hdlc_stat_readmux #(.W(CNT_W), .N(N_CNT), .SW(SEL_W)) u_rd (
    .sel   (reg_sel),
    .cnt   (cnt_q),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/hdlc_err_stats_chk.sv
module hdlc_err_stats_chk
  import hdlc_stat_pkg::*;
(
  input logic                        clk,
  input logic                        rst_sn,
  input logic                        chan_en,
  input logic                        rx_eof,
  input logic                        rx_crc_bad,
  input logic                        rx_overrun,
  input logic                        rx_addr_hit,
  input logic                        rx_abort,
  input logic                        tx_retry,
  input logic                        reg_wr,
  input logic [N_CNT-1:0][CNT_W-1:0] cnt_q
);
  p_locked_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    chan_en && reg_wr && !rx_eof && !rx_abort && !tx_retry |=> $stable(cnt_q));

  p_crc_step_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    chan_en && rx_eof && rx_crc_bad && !rx_overrun
    |=> cnt_q[IDX_CRC] == $past(cnt_q[IDX_CRC]) + 16'd1);

  p_ovr_skip_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    chan_en && rx_eof && rx_overrun
    |=> $stable(cnt_q[IDX_CRC]) && $stable(cnt_q[IDX_NMA]) && $stable(cnt_q[IDX_DISC]));

  p_abort_step_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    chan_en && rx_abort |=> cnt_q[IDX_ABT] == $past(cnt_q[IDX_ABT]) + 16'd1);

  p_nomatch_step_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    chan_en && rx_eof && !rx_crc_bad && !rx_overrun && !rx_addr_hit
    |=> cnt_q[IDX_NMA] == $past(cnt_q[IDX_NMA]) + 16'd1);

  p_retry_step_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    chan_en && tx_retry |=> cnt_q[IDX_RTX] == $past(cnt_q[IDX_RTX]) + 16'd1);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    !chan_en && !reg_wr |=> $stable(cnt_q));
endmodule

bind hdlc_err_stats hdlc_err_stats_chk u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .chan_en     (chan_en),
  .rx_eof      (rx_eof),
  .rx_crc_bad  (rx_crc_bad),
  .rx_overrun  (rx_overrun),
  .rx_addr_hit (rx_addr_hit),
  .rx_abort    (rx_abort),
  .tx_retry    (tx_retry),
  .reg_wr      (reg_wr),
  .cnt_q       (cnt_q)
);

// File: tb/test_hdlc_err_stats.sv
module test_hdlc_err_stats;
  logic        clk = 1'b0;
  logic        rst_n, chan_en, rx_eof, rx_crc_bad, rx_overrun, rx_addr_hit;
  logic        rx_no_buf, rx_busy, rx_abort, tx_retry, reg_wr;
  logic [2:0]  reg_sel;
  logic [15:0] reg_wdata, reg_rdata;
  logic [15:0] exp_c [5];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hdlc_err_stats i_hdlc_err_stats (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rx_eof(rx_eof),
    .rx_crc_bad(rx_crc_bad), .rx_overrun(rx_overrun), .rx_addr_hit(rx_addr_hit),
    .rx_no_buf(rx_no_buf), .rx_busy(rx_busy), .rx_abort(rx_abort),
    .tx_retry(tx_retry), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic string tag_of(int i);
    case (i)
      0: return "R9";
      1: return "R4";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(int idx, string req);
    reg_sel = 3'(idx);
    #0.5;
    check(req, reg_rdata, (idx < 5) ? exp_c[idx] : 16'h0);
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < 5; i++) read_chk(i, req);
  endtask

  task automatic clr_in();
    rx_eof = 0; rx_crc_bad = 0; rx_overrun = 0; rx_addr_hit = 0;
    rx_no_buf = 0; rx_busy = 0; rx_abort = 0; tx_retry = 0; reg_wr = 0;
  endtask

  task automatic sw_write(int idx, logic [15:0] v);
    @(negedge clk);
    reg_sel = 3'(idx); reg_wdata = v; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  // one cycle of strobes with status bits v = {eof,crc,ovr,hit,nobuf,busy,abort,retry}
  task automatic pulse(logic [7:0] v);
    @(negedge clk);
    {rx_eof, rx_crc_bad, rx_overrun, rx_addr_hit, rx_no_buf, rx_busy, rx_abort, tx_retry} = v;
    @(negedge clk);
    clr_in();
  endtask

  // independent model of the counting rules
  task automatic model(logic [7:0] v, bit en);
    bit eof = v[7], crc = v[6], ovr = v[5], hit = v[4], nb = v[3], bsy = v[2];
    bit good = !crc && !ovr;
    if (!en) return;
    if (eof && good && hit && (nb || bsy)) exp_c[0] = exp_c[0] + 16'd1;
    if (eof && crc && !ovr)                exp_c[1] = exp_c[1] + 16'd1;
    if (v[1])                              exp_c[2] = exp_c[2] + 16'd1;
    if (eof && good && !hit)               exp_c[3] = exp_c[3] + 16'd1;
    if (v[0])                              exp_c[4] = exp_c[4] + 16'd1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clr_in(); chan_en = 0; reg_sel = 0; reg_wdata = 0; rst_n = 0;
    for (int i = 0; i < 5; i++) exp_c[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    read_all("R12 reset");

    // R3 preset while disabled, distinct values
    for (int i = 0; i < 5; i++) begin
      exp_c[i] = 16'h1000 * 16'(i + 1) + 16'h0011;
      sw_write(i, exp_c[i]);
    end
    read_all("R3 preload");
    read_chk(5, "R13 unused"); read_chk(6, "R13 unused"); read_chk(7, "R13 unused");

    // R11 strobes while disabled do nothing
    pulse(8'hFF); pulse(8'h83);
    read_all("R11 disabled");

    // R11 enable toggling preserves values
    @(negedge clk); chan_en = 1;
    @(negedge clk); chan_en = 0;
    @(negedge clk); chan_en = 1;
    read_all("R11 toggle");

    // R2 writes while enabled ignored
    for (int i = 0; i < 5; i++) sw_write(i, 16'hDEAD);
    read_all("R2 locked");

    // exhaustive sweep of every status combination (R4..R10 incl. R5 overrun)
    for (int c = 0; c < 256; c++) begin
      pulse(8'(c));
      model(8'(c), 1'b1);
      for (int i = 0; i < 5; i++) read_chk(i, tag_of(i));
    end

    // R1 wrap on every tally, all events at once (R10)
    @(negedge clk); chan_en = 0;
    for (int i = 0; i < 5; i++) begin
      sw_write(i, 16'hFFFF); exp_c[i] = 16'hFFFF;
    end
    @(negedge clk); chan_en = 1;
    pulse(8'b1001_1011); model(8'b1001_1011, 1'b1); // matched, no buffer: discard + abort + retry
    pulse(8'b1100_0000); model(8'b1100_0000, 1'b1); // CRC error
    pulse(8'b1000_0000); model(8'b1000_0000, 1'b1); // no match
    read_all("R1 wrap");
    check("R1 wrap value", exp_c[2], 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule